// File: doc/BRIEF.md
# Two-Channel PCM Frame Port

This block is the digital edge of a two-channel voice converter. It moves 8-bit samples between parallel words on the core side and serial PCM lines on the board side. Everything runs on one free-running system clock. The external bit clock and the two frame syncs are oversampled, and their edges are found inside the block. Transmit samples enter as a pair through a valid/ready handshake. A single holding register backs that handshake. While the register holds a pair, `tx_ready` is low and the producer must keep `tx_valid`, `tx_a` and `tx_b` steady. A frame start empties the register. Receive samples leave as a pair on `rx_valid`/`rx_ready`. A pair stays presented until it is accepted. There is no back-pressure toward the line, so a newer frame replaces a pair that has not yet been taken.

The `par_mode` input selects the line layout and may change only between frames. In parallel layout, each channel has its own input line and its own output line, and the two slots have identical timing. In multiplexed layout, one 16-bit slot carries channel A then channel B. That slot arrives on the B input line and leaves on the A output line. Output lines behave as open-drain drivers: a line's level counts only while its enable is high. Each enable is low outside its own slot. A bit clock or transmit sync that stops toggling puts the block into power save, and so does the power-down input.

Top module: `pcm2_port`

## Requirements
- R1: After reset both output enables are low, `tx_ready` is high, `rx_valid` is low and `psave` is low.
- R2: A transmit frame starts at a bit-clock rise where `tx_fsync` is high and was low at the previous rise. The first bit (the sample MSB) is driven from that rise. Each following bit is driven from the next rise, and the line does not change between rises.
- R3: In parallel layout each output enable is high for exactly 8 bit periods from the frame start. In multiplexed layout `pcm_oe_b` stays low.
- R4: In multiplexed layout `pcm_out_a` carries a 16-bit slot: bits 15..8 hold `tx_a` and bits 7..0 hold `tx_b`, MSB first.
- R5: Receive bits are sampled on bit-clock falls. Sampling starts at the first fall after a rise where `rx_fsync` is first seen high. In parallel layout, after the 8th fall `rx_a` holds the `pcm_in_a` byte and `rx_b` holds the `pcm_in_b` byte, MSB first, and `rx_valid` is set.
- R6: In multiplexed layout 16 bits are taken from `pcm_in_b`. The first 8 go to `rx_a` and the last 8 to `rx_b`, and `pcm_in_a` is ignored.
- R7: An accepted transmit pair drops `tx_ready` until the next frame start, which loads the pair and raises `tx_ready` again. A frame start with no pair held drives nothing.
- R8: `rx_valid` holds until `rx_ready` is seen high. A frame that completes before that replaces the pair.
- R9: No bit-clock transition for BCLK_TMO system clocks sets `psave`. While `psave` is set both enables are low and no receive pair is delivered.
- R10: No `tx_fsync` transition for SYNC_TMO system clocks sets `psave`.
- R11: `psave` clears at the next transmit frame start, and that frame is transmitted and received normally.
- R12: While `pwr_dn_n` is low both enables are low in the same cycle, any slot in progress is abandoned, and `rx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the line signals |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn_n | input | 1 | Active-low power-down |
| par_mode | input | 1 | 1 selects parallel layout, 0 selects multiplexed layout |
| bit_clk | input | 1 | External bit clock |
| tx_fsync | input | 1 | Transmit frame sync |
| rx_fsync | input | 1 | Receive frame sync |
| pcm_in_a | input | 1 | Receive line A (parallel layout only) |
| pcm_in_b | input | 1 | Receive line B, or the multiplexed receive line |
| pcm_out_a | output | 1 | Transmit line A level, or the multiplexed line level |
| pcm_oe_a | output | 1 | Drive enable for line A |
| pcm_out_b | output | 1 | Transmit line B level |
| pcm_oe_b | output | 1 | Drive enable for line B |
| tx_valid | input | 1 | Transmit pair offered |
| tx_ready | output | 1 | Holding register empty |
| tx_a | input | SW | Channel A transmit sample |
| tx_b | input | SW | Channel B transmit sample |
| rx_valid | output | 1 | Receive pair available |
| rx_ready | input | 1 | Receive pair accepted |
| rx_a | output | SW | Channel A receive sample |
| rx_b | output | SW | Channel B receive sample |
| psave | output | 1 | Power save from lost bit clock or transmit sync |

## Verification
A wrong bit counter or slot length appears within one frame, as an enable that stays high for the wrong number of bit periods. A wrong shift order appears as wrong line levels. A receive assembler that is misaligned or reads the wrong line delivers a wrong pair 8 or 16 bit periods after the sync. Errors in the holding register show at `tx_ready` and in whether the next slot is driven. Errors in the watchdog show as `psave` and silent lines after the timeout, or as a frame that fails to resume once activity returns.

// File: rtl/pcm2_pkg.sv
package pcm2_pkg;
  parameter int SAMPLE_W = 8;
  parameter int LINE_W   = 5;
  typedef enum logic [2:0] {
    L_IN_B = 3'd0, L_IN_A = 3'd1, L_RXS = 3'd2, L_TXS = 3'd3, L_BCK = 3'd4
  } line_idx_e;
endpackage

// File: rtl/pcm2_sampler.sv
module pcm2_sampler #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prv_o
);
  for (genvar g = 0; g < W; g++) begin : g_line
    logic c_q, p_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c_q <= 1'b0;
        p_q <= 1'b0;
      end else begin
        c_q <= raw_i[g];
        p_q <= c_q;
      end
    end
    assign cur_o[g] = c_q;
    assign prv_o[g] = p_q;
  end
endmodule

// File: rtl/pcm2_watch.sv
module pcm2_watch #(
  parameter int BCLK_TMO = 4000,
  parameter int SYNC_TMO = 40000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_edge,
  input  logic sync_edge,
  input  logic frame_start,
  output logic psave
);
  localparam int BW = $clog2(BCLK_TMO + 1);
  localparam int YW = $clog2(SYNC_TMO + 1);
  logic [BW-1:0] b_idle;
  logic [YW-1:0] y_idle;
  logic          stuck;

  assign stuck = (b_idle == BW'(BCLK_TMO)) || (y_idle == YW'(SYNC_TMO));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_idle <= '0;
      y_idle <= '0;
      psave  <= 1'b0;
    end else begin
      if (bclk_edge) b_idle <= '0;
      else if (b_idle != BW'(BCLK_TMO)) b_idle <= b_idle + 1'b1;
      if (sync_edge) y_idle <= '0;
      else if (y_idle != YW'(SYNC_TMO)) y_idle <= y_idle + 1'b1;
      if (frame_start) psave <= 1'b0;
      else if (stuck) psave <= 1'b1;
    end
  end

  p_resume_at_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(psave) |-> $past(frame_start));
endmodule

// File: rtl/pcm2_tx.sv
module pcm2_tx #(
  parameter int SW = pcm2_pkg::SAMPLE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_dn_n,
  input  logic          par_mode,
  input  logic          b_rise,
  input  logic          sync_s,
  input  logic          psave,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [SW-1:0] tx_a,
  input  logic [SW-1:0] tx_b,
  output logic          frame_start,
  output logic          pcm_out_a,
  output logic          pcm_oe_a,
  output logic          pcm_out_b,
  output logic          pcm_oe_b
);
  localparam int FW = 2 * SW;
  localparam int CW = $clog2(FW + 1);
  logic [FW-1:0] sh_a;
  logic [SW-1:0] sh_b, hold_a, hold_b;
  logic          full, active, sync_last;
  logic [CW-1:0] cnt, last_idx;

  assign frame_start = b_rise && sync_s && !sync_last;
  assign last_idx    = par_mode ? CW'(SW - 1) : CW'(FW - 1);
  assign tx_ready    = !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_a <= '0; sh_b <= '0; hold_a <= '0; hold_b <= '0;
      full <= 1'b0; active <= 1'b0; sync_last <= 1'b0; cnt <= '0;
    end else begin
      if (tx_valid && !full) begin
        hold_a <= tx_a;
        hold_b <= tx_b;
        full   <= 1'b1;
      end
      if (b_rise) sync_last <= sync_s;
      if (!pwr_dn_n) begin
        active <= 1'b0;
      end else if (frame_start) begin
        active <= full;
        cnt    <= '0;
        if (full) begin
          sh_a <= {hold_a, hold_b};
          sh_b <= hold_b;
          full <= 1'b0;
        end
      end else if (b_rise && active) begin
        if (cnt == last_idx) active <= 1'b0;
        else begin
          cnt  <= cnt + 1'b1;
          sh_a <= sh_a << 1;
          sh_b <= sh_b << 1;
        end
      end
    end
  end

  assign pcm_out_a = sh_a[FW-1];
  assign pcm_out_b = sh_b[SW-1];
  assign pcm_oe_a  = active && pwr_dn_n && !psave;
  assign pcm_oe_b  = active && pwr_dn_n && !psave && par_mode;

  p_bits_move_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !b_rise) |=> $stable(pcm_out_a));
  p_hold_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
endmodule

// File: rtl/pcm2_rx.sv
module pcm2_rx #(
  parameter int SW = pcm2_pkg::SAMPLE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_dn_n,
  input  logic          par_mode,
  input  logic          b_rise,
  input  logic          b_fall,
  input  logic          sync_s,
  input  logic          in_a,
  input  logic          in_b,
  input  logic          psave,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [SW-1:0] rx_a,
  output logic [SW-1:0] rx_b
);
  localparam int FW = 2 * SW;
  localparam int CW = $clog2(FW + 1);
  logic [FW-1:0] sh_a, nxt_a;
  logic [SW-1:0] sh_b, nxt_b;
  logic          armed, sync_last, start;
  logic [CW-1:0] cnt, last_idx;

  assign start    = b_rise && sync_s && !sync_last;
  assign last_idx = par_mode ? CW'(SW - 1) : CW'(FW - 1);
  assign nxt_a    = {sh_a[FW-2:0], par_mode ? in_a : in_b};
  assign nxt_b    = {sh_b[SW-2:0], in_b};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_a <= '0; sh_b <= '0; armed <= 1'b0; sync_last <= 1'b0;
      cnt <= '0; rx_valid <= 1'b0; rx_a <= '0; rx_b <= '0;
    end else begin
      if (b_rise) sync_last <= sync_s;
      if (!pwr_dn_n) begin
        armed    <= 1'b0;
        rx_valid <= 1'b0;
      end else begin
        if (rx_valid && rx_ready) rx_valid <= 1'b0;
        if (start) begin
          armed <= 1'b1;
          cnt   <= '0;
        end else if (b_fall && armed) begin
          sh_a <= nxt_a;
          sh_b <= nxt_b;
          if (cnt == last_idx) begin
            armed <= 1'b0;
            if (!psave) begin
              rx_valid <= 1'b1;
              rx_a     <= par_mode ? nxt_a[SW-1:0] : nxt_a[FW-1:SW];
              rx_b     <= par_mode ? nxt_b : nxt_a[SW-1:0];
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  p_pair_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && pwr_dn_n && !(b_fall && armed)) |=> (rx_valid && $stable(rx_a) && $stable(rx_b)));
  p_quiet_in_pdn_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_dn_n |=> !rx_valid);
endmodule

// File: rtl/pcm2_port.sv
module pcm2_port #(
  parameter int SW       = pcm2_pkg::SAMPLE_W,
  parameter int BCLK_TMO = 4000,
  parameter int SYNC_TMO = 40000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_dn_n,
  input  logic          par_mode,
  input  logic          bit_clk,
  input  logic          tx_fsync,
  input  logic          rx_fsync,
  input  logic          pcm_in_a,
  input  logic          pcm_in_b,
  output logic          pcm_out_a,
  output logic          pcm_oe_a,
  output logic          pcm_out_b,
  output logic          pcm_oe_b,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [SW-1:0] tx_a,
  input  logic [SW-1:0] tx_b,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [SW-1:0] rx_a,
  output logic [SW-1:0] rx_b,
  output logic          psave
);
  import pcm2_pkg::*;
  logic [LINE_W-1:0] raw, cur, prv;
  logic b_rise, b_fall, frame_start;

  assign raw[L_BCK]  = bit_clk;
  assign raw[L_TXS]  = tx_fsync;
  assign raw[L_RXS]  = rx_fsync;
  assign raw[L_IN_A] = pcm_in_a;
  assign raw[L_IN_B] = pcm_in_b;

  pcm2_sampler #(.W(LINE_W)) u_smp (
    .clk(clk), .rst_n(rst_n), .raw_i(raw), .cur_o(cur), .prv_o(prv));

  assign b_rise = cur[L_BCK] && !prv[L_BCK];
  assign b_fall = !cur[L_BCK] && prv[L_BCK];

  pcm2_watch #(.BCLK_TMO(BCLK_TMO), .SYNC_TMO(SYNC_TMO)) u_watch (
    .clk(clk), .rst_n(rst_n), .bclk_edge(b_rise || b_fall),
    .sync_edge(cur[L_TXS] != prv[L_TXS]), .frame_start(frame_start), .psave(psave));

  pcm2_tx #(.SW(SW)) u_tx (
    .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n), .par_mode(par_mode),
    .b_rise(b_rise), .sync_s(cur[L_TXS]), .psave(psave),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_a(tx_a), .tx_b(tx_b),
    .frame_start(frame_start), .pcm_out_a(pcm_out_a), .pcm_oe_a(pcm_oe_a),
    .pcm_out_b(pcm_out_b), .pcm_oe_b(pcm_oe_b));

  pcm2_rx #(.SW(SW)) u_rx (
    .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n), .par_mode(par_mode),
    .b_rise(b_rise), .b_fall(b_fall), .sync_s(cur[L_RXS]),
    .in_a(cur[L_IN_A]), .in_b(cur[L_IN_B]), .psave(psave),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_a(rx_a), .rx_b(rx_b));

  p_no_pair_in_save_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> !$past(psave));
  p_release_in_save_r9: assert property (@(posedge clk) disable iff (!rst_n)
    psave |-> (!pcm_oe_a && !pcm_oe_b));
endmodule

// File: tb/pcm2_port_test.sv
`timescale 1ns/1ps
module pcm2_port_test;
  localparam int SW = 8;
  logic clk = 1'b0, rst_n = 1'b0, pwr_dn_n = 1'b1, par_mode = 1'b1;
  logic bit_clk = 1'b0, tx_fsync = 1'b0, rx_fsync = 1'b0, pcm_in_a = 1'b0, pcm_in_b = 1'b0;
  logic pcm_out_a, pcm_oe_a, pcm_out_b, pcm_oe_b, tx_ready, rx_valid, psave;
  logic tx_valid = 1'b0, rx_ready = 1'b0;
  logic [SW-1:0] tx_a = '0, tx_b = '0, rx_a, rx_b;
  logic [31:0] cap_oa, cap_da, cap_ob, cap_db;
  int n_chk = 0, n_err = 0, cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pcm2_port #(.SW(SW), .BCLK_TMO(64), .SYNC_TMO(600)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n), .par_mode(par_mode),
    .bit_clk(bit_clk), .tx_fsync(tx_fsync), .rx_fsync(rx_fsync),
    .pcm_in_a(pcm_in_a), .pcm_in_b(pcm_in_b), .pcm_out_a(pcm_out_a), .pcm_oe_a(pcm_oe_a),
    .pcm_out_b(pcm_out_b), .pcm_oe_b(pcm_oe_b), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_a(tx_a), .tx_b(tx_b), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_a(rx_a), .rx_b(rx_b), .psave(psave));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  task automatic send_word(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    tx_a = a; tx_b = b; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  // 32 bit periods of 8 system clocks; line bits change at rises
  task automatic run_frame(input bit sync_on, input bit rsync_on, input logic [15:0] line_a,
                           input logic [15:0] line_b, input int pdn_slot);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      bit_clk = 1'b1;
      tx_fsync = sync_on && (i == 0);
      rx_fsync = rsync_on && (i == 0);
      pcm_in_a = (i < 16) ? line_a[15-i] : 1'b1;
      pcm_in_b = (i < 16) ? line_b[15-i] : 1'b1;
      if (i == pdn_slot) pwr_dn_n = 1'b0;
      repeat (3) @(negedge clk);
      cap_oa[31-i] = pcm_oe_a; cap_da[31-i] = pcm_oe_a & pcm_out_a;
      cap_ob[31-i] = pcm_oe_b; cap_db[31-i] = pcm_oe_b & pcm_out_b;
      @(negedge clk);
      bit_clk = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 oe_a", {31'b0, pcm_oe_a}, 0);
    chk("R1 oe_b", {31'b0, pcm_oe_b}, 0);
    chk("R1 tx_ready", {31'b0, tx_ready}, 1);
    chk("R1 rx_valid", {31'b0, rx_valid}, 0);
    chk("R1 psave", {31'b0, psave}, 0);
  endtask

  task automatic t_parallel();
    par_mode = 1'b1;
    send_word(8'hB4, 8'h3C);
    @(negedge clk);
    chk("R7 ready low while held", {31'b0, tx_ready}, 0);
    run_frame(1, 1, 16'hC9_00, 16'h5E_00, -1);
    chk("R3 parallel oe_a", cap_oa, 32'hFF00_0000);
    chk("R2 parallel line a", cap_da, 32'hB400_0000);
    chk("R3 parallel oe_b", cap_ob, 32'hFF00_0000);
    chk("R2 parallel line b", cap_db, 32'h3C00_0000);
    chk("R7 ready after start", {31'b0, tx_ready}, 1);
    chk("R5 rx_valid", {31'b0, rx_valid}, 1);
    chk("R5 rx pair", {16'b0, rx_a, rx_b}, 32'hC95E);
    pop();
    chk("R8 popped", {31'b0, rx_valid}, 0);
  endtask

  task automatic t_no_word();
    run_frame(1, 0, 16'h0, 16'h0, -1);
    chk("R7 nothing held no slot", cap_oa | cap_ob, 0);
  endtask

  task automatic t_serial();
    par_mode = 1'b0;
    send_word(8'h81, 8'h6A);
    run_frame(1, 1, 16'hFFFF, 16'h2D_E7, -1);
    chk("R4 serial oe_a", cap_oa, 32'hFFFF_0000);
    chk("R4 serial line a", cap_da, 32'h816A_0000);
    chk("R3 serial oe_b quiet", cap_ob, 0);
    chk("R6 serial rx pair", {15'b0, rx_valid, rx_a, rx_b}, 32'h1_2DE7);
    pop();
    par_mode = 1'b1;
  endtask

  task automatic t_overwrite();
    run_frame(1, 1, 16'h11_00, 16'h22_00, -1);
    repeat (20) @(negedge clk);
    chk("R8 held unaccepted", {15'b0, rx_valid, rx_a, rx_b}, 32'h1_1122);
    run_frame(1, 1, 16'h77_00, 16'h99_00, -1);
    chk("R8 replaced", {15'b0, rx_valid, rx_a, rx_b}, 32'h1_7799);
    pop();
  endtask

  task automatic t_bclk_stop();
    run_frame(1, 0, 16'h0, 16'h0, -1);
    chk("R9 active no save", {31'b0, psave}, 0);
    send_word(8'hE2, 8'h17);
    repeat (100) @(negedge clk);
    chk("R9 save on stopped clock", {29'b0, psave, pcm_oe_a, pcm_oe_b}, 32'h4);
    run_frame(1, 1, 16'h42_00, 16'hA1_00, -1);
    chk("R11 resumed line a", cap_da, 32'hE200_0000);
    chk("R11 resumed line b", cap_db, 32'h1700_0000);
    chk("R11 resumed rx", {14'b0, psave, rx_valid, rx_a, rx_b}, 32'h1_42A1);
    pop();
  endtask

  task automatic t_sync_stop();
    send_word(8'h5A, 8'hC3);
    for (int k = 0; k < 3; k++) run_frame(0, 0, 16'h0, 16'h0, -1);
    chk("R10 save on stuck sync", {31'b0, psave}, 1);
    run_frame(0, 1, 16'h66_00, 16'h33_00, -1);
    chk("R9 no rx pair in save", {31'b0, rx_valid}, 0);
    chk("R9 lines quiet in save", cap_oa | cap_ob, 0);
    run_frame(1, 0, 16'h0, 16'h0, -1);
    chk("R11 resumed after sync", {31'b0, psave}, 0);
    chk("R11 held word sent", cap_da | cap_db, 32'h5A00_0000 | 32'hC300_0000);
  endtask

  task automatic t_pdn();
    send_word(8'hA7, 8'hFF);
    run_frame(1, 1, 16'hFF_00, 16'hFF_00, 3);
    chk("R12 oe_a cut", cap_oa, 32'hE000_0000);
    chk("R12 oe_b cut", cap_ob, 32'hE000_0000);
    chk("R12 bits before cut", cap_da, 32'hA000_0000);
    chk("R12 no rx pair", {31'b0, rx_valid}, 0);
    pwr_dn_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_parallel();
    t_no_word();
    t_serial();
    t_overwrite();
    t_bclk_stop();
    t_sync_stop();
    t_pdn();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule